// File: doc/BRIEF.md
# Audio Serial Bit-Clock and Word-Select Generator

This block produces the two timing clocks that an I2S-style audio transmitter needs: a serial bit clock and a word-select (left/right) clock. One of two incoming clocks is picked as the source. The choice goes through a switch that cannot glitch: it shuts off the old clock before it opens the new one. The chosen source is divided by a programmable 8-bit ratio to form the bit clock. A second, 6-bit programmable ratio sets how many bit-clock periods make up each half of the word-select clock.

An odd bit-clock ratio cannot give an even split. A polarity input therefore decides whether the high half or the low half gets the extra source cycle. Ratio codes that are too small are forced up to the smallest legal ratio, so the output keeps running, and a sticky flag records the event. A new ratio is taken only when the running period ends, so no output pulse is ever cut short. Dropping the enable stops both outputs low and clears every count.

Top module: `i2s_clkgen`

## Requirements
- R1: With `src_sel` at 0 the dividers run from `clk_a`, and with `src_sel` at 1 they run from `clk_b`. The two internal source gates are never open at the same time.
- R2: A bit-clock code from 3 to 255 divides by the code value. Code 0 divides by 256.
- R3: With an even ratio, the bit clock stays high and low for equal numbers of source cycles.
- R4: With an odd ratio and `odd_hi` at 1, the high half is one source cycle longer than the low half.
- R5: With an odd ratio and `odd_hi` at 0, the low half is one source cycle longer than the high half.
- R6: One source edge after `en` is first sampled high, `bclk_o` goes high. Every bit-clock period begins with its high half.
- R7: `ws_o` starts low and toggles at the same source edge as a falling edge of `bclk_o`, once every N bit-clock periods. N is the word-select code from 1 to 63, and code 0 gives N = 64.
- R8: A bit-clock code of 1 or 2 divides by 3. It also sets `cfg_err_o` one source edge later, and `cfg_err_o` stays set until reset.
- R9: A new bit-clock code takes effect only at the end of the current bit-clock period. A new word-select code takes effect only at a `ws_o` toggle.
- R10: While `en` is low, `bclk_o` and `ws_o` are low from the next source edge on, and all counts restart from zero when `en` returns high.
- R11: Synchronous reset drives `bclk_o`, `ws_o` and `cfg_err_o` low and selects `clk_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source clock 0 (system clock) |
| clk_b | input | 1 | Source clock 1 (PLL clock) |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 1 | Source select: 0 = clk_a, 1 = clk_b |
| bdiv | input | 8 | Bit-clock ratio code (0 = 256) |
| wdiv | input | 6 | Word-select ratio code in bit-clock periods (0 = 64) |
| odd_hi | input | 1 | Odd-ratio polarity: 1 = longer high half |
| en | input | 1 | Run enable |
| bclk_o | output | 1 | Bit clock, registered |
| ws_o | output | 1 | Word-select clock, registered |
| cfg_err_o | output | 1 | Sticky flag for an illegal bit-clock code |

## Verification
Every output is a register on the selected source clock. After an input is sampled at a source edge, `bclk_o`, `cfg_err_o` and the stop on disable show up one edge later. `ws_o` first toggles at the N-th bit-clock falling edge, which with ratio 4 and N = 3 is the 11th edge after enable. The bench changes inputs on falling edges of `clk_a` and samples outputs on later falling edges. Half widths are counted as runs of those samples. While `clk_b` is the source, the bench measures them as simulation time between output edges.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
  localparam int BDIV_W    = 8;  // bit-clock ratio code width
  localparam int WDIV_W    = 6;  // word-select ratio code width
  localparam int MIN_RATIO = 3;  // smallest legal bit-clock ratio
endpackage

// File: rtl/clk_glitchless_mux.sv
module clk_glitchless_mux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic sel,
  output logic clk_o,
  output logic gate_a,
  output logic gate_b
);
  logic req_a, req_b;

  // request side: ask for a clock only once the other gate has closed
  always_ff @(posedge clk_a) begin
    if (rst) req_a <= 1'b1;
    else     req_a <= !sel && !gate_b;
  end

  always_ff @(negedge clk_a) begin
    if (rst) gate_a <= 1'b1;
    else     gate_a <= req_a;
  end

  always_ff @(posedge clk_b) begin
    if (rst) req_b <= 1'b0;
    else     req_b <= sel && !gate_a;
  end

  always_ff @(negedge clk_b) begin
    if (rst) gate_b <= 1'b0;
    else     gate_b <= req_b;
  end

  // gates change only while their own clock is low
  assign clk_o = (clk_a & gate_a) | (clk_b & gate_b);
endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
  import i2s_clkgen_pkg::*;
#(
  parameter int W = BDIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] code,
  input  logic         odd_hi,
  output logic         bclk,
  output logic         fall_tick,
  output logic         err
);
  localparam logic [W-1:0] LAST_FLOOR = W'(MIN_RATIO - 1);

  logic [W-1:0] last_n, hi_n;
  logic [W-1:0] cnt, last_q, hi_q;
  logic         running, illegal, at_end;

  // decode code to (ratio-1) and the high-half length
  always_comb begin
    illegal = (code != '0) && (code < W'(MIN_RATIO));
    if (code == '0)   last_n = '1;
    else if (illegal) last_n = LAST_FLOOR;
    else              last_n = code - 1'b1;
    hi_n = W'(({1'b0, last_n} + (W+1)'(1)) >> 1) + W'((~last_n[0]) & odd_hi);
  end

  assign at_end    = running && (cnt == last_q);
  assign fall_tick = running && !at_end &&
                     (({1'b0, cnt} + (W+1)'(1)) == {1'b0, hi_q});

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running <= 1'b0;
      cnt     <= '0;
      bclk    <= 1'b0;
      last_q  <= last_n;
      hi_q    <= hi_n;
    end else if (!running || at_end) begin
      running <= 1'b1;
      cnt     <= '0;
      bclk    <= 1'b1;
      last_q  <= last_n;
      hi_q    <= hi_n;
    end else begin
      cnt <= cnt + 1'b1;
      if (fall_tick) bclk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                err <= 1'b0;
    else if (en && illegal) err <= 1'b1;
  end
endmodule

// File: rtl/wsel_divider.sv
module wsel_divider
  import i2s_clkgen_pkg::*;
#(
  parameter int W = WDIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] code,
  input  logic         tick,
  output logic         ws
);
  logic [W-1:0] last_n, cnt, last_q;

  assign last_n = (code == '0) ? '1 : code - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      ws     <= 1'b0;
      last_q <= last_n;
    end else if (tick) begin
      if (cnt == last_q) begin
        cnt    <= '0;
        ws     <= !ws;
        last_q <= last_n;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int BW = BDIV_W,
  parameter int WW = WDIV_W
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst,
  input  logic          src_sel,
  input  logic [BW-1:0] bdiv,
  input  logic [WW-1:0] wdiv,
  input  logic          odd_hi,
  input  logic          en,
  output logic          bclk_o,
  output logic          ws_o,
  output logic          cfg_err_o
);
  logic src_clk, gate_a, gate_b, fall_tick;

  clk_glitchless_mux u_mux (
    .clk_a (clk_a),
    .clk_b (clk_b),
    .rst   (rst),
    .sel   (src_sel),
    .clk_o (src_clk),
    .gate_a(gate_a),
    .gate_b(gate_b)
  );

  bclk_divider #(.W(BW)) u_bdiv (
    .clk      (src_clk),
    .rst      (rst),
    .en       (en),
    .code     (bdiv),
    .odd_hi   (odd_hi),
    .bclk     (bclk_o),
    .fall_tick(fall_tick),
    .err      (cfg_err_o)
  );

  wsel_divider #(.W(WW)) u_wdiv (
    .clk (src_clk),
    .rst (rst),
    .en  (en),
    .code(wdiv),
    .tick(fall_tick),
    .ws  (ws_o)
  );
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk #(
  parameter int BW = 8
) (
  input logic          sclk,
  input logic          clk_a,
  input logic          rst,
  input logic          en,
  input logic [BW-1:0] bdiv,
  input logic          bclk,
  input logic          ws,
  input logic          err,
  input logic          gate_a,
  input logic          gate_b
);
  // R1: never two source gates open
  a_r1_one_source: assert property (@(posedge clk_a) disable iff (rst)
    $onehot0({gate_a, gate_b}));

  // R6: enable start gives a high bit clock one edge later
  a_r6_start_high: assert property (@(posedge sclk) disable iff (rst)
    (en && !$past(en)) |=> bclk);

  // R7: word select moves only together with a bit-clock fall
  a_r7_ws_on_fall: assert property (@(posedge sclk) disable iff (rst)
    (en && $past(en) && (ws != $past(ws))) |-> ($past(bclk) && !bclk));

  // R8: illegal code raises the flag
  a_r8_flag_sets: assert property (@(posedge sclk) disable iff (rst)
    (en && (bdiv == BW'(1) || bdiv == BW'(2))) |=> err);

  // R8: flag is sticky
  a_r8_flag_sticky: assert property (@(posedge sclk) disable iff (rst)
    err |=> err);

  // R10: outputs low while disabled
  a_r10_off_low: assert property (@(posedge sclk) disable iff (rst)
    !$past(en) |-> (!bclk && !ws));
endmodule

bind i2s_clkgen i2s_clkgen_chk #(.BW(BW)) u_chk (
  .sclk  (src_clk),
  .clk_a (clk_a),
  .rst   (rst),
  .en    (en),
  .bdiv  (bdiv),
  .bclk  (bclk_o),
  .ws    (ws_o),
  .err   (cfg_err_o),
  .gate_a(gate_a),
  .gate_b(gate_b)
);

// File: tb/sim_i2s_clkgen.sv
module sim_i2s_clkgen;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int GUARD        = 5000;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst = 1'b1, sel = 1'b0, pol = 1'b0, en = 1'b0;
  logic [7:0] bdiv = '0;
  logic [5:0] wdiv = '0;
  logic bclk, ws, err;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2)   clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  i2s_clkgen u0 (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .src_sel(sel),
    .bdiv(bdiv), .wdiv(wdiv), .odd_hi(pol), .en(en),
    .bclk_o(bclk), .ws_o(ws), .cfg_err_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a clk_a falling edge; counts one full bit-clock period
  task automatic measure(output int h, output int l);
    int g;
    g = 0; h = 0; l = 0;
    while (!bclk && g < GUARD) begin @(negedge clk_a); g++; end
    while (bclk && h < GUARD)  begin h++; @(negedge clk_a); end
    while (!bclk && l < GUARD) begin l++; @(negedge clk_a); end
  endtask

  // code, odd_hi, expected high, expected low
  localparam int VEC[10][4] = '{
    '{  4, 1,   2,   2},   // R3 even
    '{150, 0,  75,  75},   // R2 R3
    '{  0, 1, 128, 128},   // R2 code 0 = 256
    '{  3, 1,   2,   1},   // R4
    '{255, 1, 128, 127},   // R4
    '{  3, 0,   1,   2},   // R5
    '{255, 0, 127, 128},   // R5
    '{  7, 0,   3,   4},   // R5
    '{  1, 1,   2,   1},   // R8 code 1 -> 3
    '{  2, 0,   1,   2}    // R8 code 2 -> 3
  };

  initial begin
    int h, l, n;
    longint t0, t1, t2;
    repeat (8) @(negedge clk_a);
    rst = 1'b0;
    @(negedge clk_a);
    check("R11 bclk after reset", bclk, 0);
    check("R11 ws after reset", ws, 0);
    check("R11 err after reset", err, 0);

    // R6: first high one edge after enable
    bdiv = 8'd4; pol = 1'b1; wdiv = 6'd3; en = 1'b1;
    @(negedge clk_a);
    check("R6 first bclk high", bclk, 1);
    check("R8 no flag on legal code", err, 0);

    for (int i = 0; i < 10; i++) begin
      en = 1'b0;
      bdiv = 8'(VEC[i][0]); pol = VEC[i][1][0];
      @(negedge clk_a);
      en = 1'b1;
      @(negedge clk_a);
      measure(h, l);
      check($sformatf("R2-vector%0d high", i), h, VEC[i][2]);
      check($sformatf("R2-vector%0d low", i), l, VEC[i][3]);
    end
    check("R8 flag set", err, 1);
    en = 1'b0; bdiv = 8'd4;
    repeat (4) @(negedge clk_a);
    check("R8 flag sticky", err, 1);

    // R9: code change mid-period waits for the period end
    en = 1'b1;
    @(negedge clk_a);
    bdiv = 8'd10;
    h = 0; l = 0;
    while (bclk && h < GUARD)  begin h++; @(negedge clk_a); end
    while (!bclk && l < GUARD) begin l++; @(negedge clk_a); end
    check("R9 old high kept", h, 2);
    check("R9 old low kept", l, 2);
    measure(h, l);
    check("R9 new high", h, 5);
    check("R9 new low", l, 5);

    // R7: word select with ratio 4, N = 3
    en = 1'b0; bdiv = 8'd4; wdiv = 6'd3;
    @(negedge clk_a);
    en = 1'b1;
    n = 0;
    do begin @(negedge clk_a); n++; end while (!ws && n < GUARD);
    check("R7 first ws toggle", n, 11);
    h = 0;
    while (ws && h < GUARD) begin h++; @(negedge clk_a); end
    check("R7 ws half width", h, 12);

    // R10: disable stops both, counts restart
    n = 0;
    while (!ws && n < GUARD) begin n++; @(negedge clk_a); end
    en = 1'b0;
    @(negedge clk_a);
    check("R10 bclk low when off", bclk, 0);
    check("R10 ws low when off", ws, 0);
    en = 1'b1;
    n = 0;
    do begin @(negedge clk_a); n++; end while (!ws && n < GUARD);
    check("R10 count restarts", n, 11);

    // R7: word-select code 0 means 64
    en = 1'b0; wdiv = 6'd0;
    @(negedge clk_a);
    en = 1'b1;
    n = 0;
    do begin @(negedge clk_a); n++; end while (!ws && n < GUARD);
    check("R7 code0 first toggle", n, 255);
    h = 0;
    while (ws && h < GUARD) begin h++; @(negedge clk_a); end
    check("R7 code0 half width", h, 256);

    // R1: run from clk_b, then back to clk_a
    en = 1'b0; sel = 1'b1; bdiv = 8'd4; pol = 1'b1;
    repeat (10) @(negedge clk_a);
    en = 1'b1;
    @(posedge bclk); t0 = $time;
    @(negedge bclk); t1 = $time;
    @(posedge bclk); t2 = $time;
    check("R1 clk_b high width", int'(t1 - t0), 2*CLK_B_PERIOD);
    check("R1 clk_b low width", int'(t2 - t1), 2*CLK_B_PERIOD);
    @(negedge clk_a);
    en = 1'b0; sel = 1'b0;
    repeat (10) @(negedge clk_a);
    en = 1'b1;
    @(negedge clk_a);
    measure(h, l);
    check("R1 back on clk_a high", h, 2);
    check("R1 back on clk_a low", l, 2);

    // R8/R11: reset clears the flag
    en = 1'b0; rst = 1'b1;
    repeat (4) @(negedge clk_a);
    rst = 1'b0;
    @(negedge clk_a);
    check("R8 flag cleared by reset", err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    total++; bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule